// File: doc/BRIEF.md
# Pattern-Cached Circuit-Switched Crossbar

This block is a centrally controlled crossbar that connects 32 bit-serial input lanes to 32 bit-serial output lanes. Every output lane takes its bit from exactly one input lane. Any input may feed any number of outputs, so every possible map of inputs onto outputs can be built. The choice of input for each output is stored as a 5-bit select.

The block keeps a cache of 32 complete connection maps on chip, and one of them is live at a time. A controller drives a small instruction port. One instruction swaps the whole live map for another cached map. A single-entry write changes one output's select inside any cached map. A load sequence rewrites a whole cached map from data supplied from outside: a start instruction followed by 32 data instructions.

The output lanes are registered, so a change of map reaches all 32 outputs on the same clock edge. No half-switched state is ever visible at the outputs.

Top module: `pattern_xbar`

## Requirements
- R1: Each output lane `outLanes[o]` is a register. At every clock edge after reset it takes `inLanes[s]`, where `s` is the 5-bit select for output `o` in the live map. Several outputs may select the same input.
- R2: While `rstN` is low, `outLanes` is all zeros and `cmdReady` is 0. After reset, `cmdReady` is 1, map 0 is live, and map 0 holds the identity (output `i` selects input `i`).
- R3: A SELECT instruction (`cmdOp` = 0) makes map `cmdPattern` live. The output value registered on the first clock edge after the accepting edge uses the new map for all 32 outputs together.
- R4: Cached maps keep their contents when they are not live. Making a map live again brings back exactly the selects it held.
- R5: A WRITE_ENTRY instruction (`cmdOp` = 1) sets entry `cmdOutput` of map `cmdPattern` to `cmdInput`. If that map is live, only output `cmdOutput` changes, and the change shows from the next registered output.
- R6: A WRITE_ENTRY to a map that is not live leaves the outputs unchanged. The new entry shows once that map is selected.
- R7: LOAD_START (`cmdOp` = 2) names map `cmdPattern` as the load target, clears `loadDone` and resets the entry count. Each following LOAD_DATA (`cmdOp` = 3) writes `cmdInput` into the next entry, starting with output 0 and going up to output 31.
- R8: `loadDone` rises after the 32nd LOAD_DATA and stays high until the next LOAD_START. A LOAD_DATA issued while no load is open has no effect.
- R9: An instruction takes effect only on an edge where both `cmdValid` and `cmdReady` are high. Otherwise the live map and the cached maps stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inLanes | input | 32 | One serial bit per input lane |
| outLanes | output | 32 | One registered serial bit per output lane |
| cmdValid | input | 1 | Instruction present |
| cmdReady | output | 1 | Instruction port accepts instructions |
| cmdOp | input | 2 | 0 SELECT, 1 WRITE_ENTRY, 2 LOAD_START, 3 LOAD_DATA |
| cmdPattern | input | 5 | Map index for SELECT, WRITE_ENTRY and LOAD_START |
| cmdOutput | input | 5 | Output lane index for WRITE_ENTRY |
| cmdInput | input | 5 | Input select for WRITE_ENTRY and LOAD_DATA |
| loadDone | output | 1 | Full-map load complete |

## Verification
If the live-map pointer or a cached entry goes wrong, some output lane carries the wrong input bit on the next registered cycle. Random input words expose such an error at once, but only while the affected map is live. For that reason, maps written while not live are selected later and checked then. A load counter that is off by one puts every later entry of that map on the wrong output, and it also moves the edge on which `loadDone` rises, so the bench checks the flag on both sides of the 32nd entry.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int LaneCount    = 32;
  localparam int PatternCount = 32;
  localparam int SelW         = $clog2(LaneCount);
  localparam int PatW         = $clog2(PatternCount);
  localparam int MapW         = LaneCount * SelW;

  typedef enum logic [1:0] {
    OP_SELECT     = 2'd0,
    OP_WRITE      = 2'd1,
    OP_LOAD_START = 2'd2,
    OP_LOAD_DATA  = 2'd3
  } xbarOp_e;

  typedef struct packed {
    logic            wrEn;
    logic [PatW-1:0] wrPat;
    logic [SelW-1:0] wrIdx;
    logic [SelW-1:0] wrSel;
    logic [PatW-1:0] livePat;
  } xbarCtl_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int Lanes = LaneCount
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic [1:0]      cmdOp,
  input  logic [PatW-1:0] cmdPattern,
  input  logic [SelW-1:0] cmdOutput,
  input  logic [SelW-1:0] cmdInput,
  output logic            loadDone,
  output xbarCtl_t        ctl
);
  localparam logic [SelW-1:0] LastIdx = SelW'(Lanes - 1);

  logic            readyQ, loadOpenQ, loadDoneQ, accept;
  logic [PatW-1:0] liveQ, loadTgtQ;
  logic [SelW-1:0] loadCntQ;
  xbarOp_e         op;

  assign op       = xbarOp_e'(cmdOp);
  assign accept   = cmdValid && readyQ;
  assign cmdReady = readyQ;
  assign loadDone = loadDoneQ;

  always_comb begin
    ctl         = '0;
    ctl.livePat = liveQ;
    if (accept && op == OP_WRITE) begin
      ctl.wrEn  = 1'b1;
      ctl.wrPat = cmdPattern;
      ctl.wrIdx = cmdOutput;
      ctl.wrSel = cmdInput;
    end else if (accept && op == OP_LOAD_DATA && loadOpenQ) begin
      ctl.wrEn  = 1'b1;
      ctl.wrPat = loadTgtQ;
      ctl.wrIdx = loadCntQ;
      ctl.wrSel = cmdInput;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      liveQ     <= '0;
      loadTgtQ  <= '0;
      loadCntQ  <= '0;
      loadOpenQ <= 1'b0;
      loadDoneQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      if (accept) begin
        unique case (op)
          OP_SELECT: liveQ <= cmdPattern;
          OP_LOAD_START: begin
            loadTgtQ  <= cmdPattern;
            loadCntQ  <= '0;
            loadOpenQ <= 1'b1;
            loadDoneQ <= 1'b0;
          end
          OP_LOAD_DATA: if (loadOpenQ) begin
            loadCntQ <= loadCntQ + 1'b1;
            if (loadCntQ == LastIdx) begin
              loadOpenQ <= 1'b0;
              loadDoneQ <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && op == OP_SELECT) |=> (liveQ == $past(cmdPattern)));
  assert_live_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && op == OP_SELECT) |=> $stable(liveQ));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadDoneQ && !(accept && op == OP_LOAD_START)) |=> loadDoneQ);
  assert_closed_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && op == OP_LOAD_DATA && loadDoneQ) |-> !ctl.wrEn);
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && op == OP_LOAD_START) |=> (!loadDoneQ && loadCntQ == '0));
endmodule

// File: rtl/xbar_path.sv
module xbar_path
  import xbar_pkg::*;
#(
  parameter int Lanes    = LaneCount,
  parameter int Patterns = PatternCount
) (
  input  logic             clk,
  input  logic             rstN,
  input  xbarCtl_t         ctl,
  input  logic [Lanes-1:0] inLanes,
  output logic [Lanes-1:0] outLanes
);
  localparam int Width = Lanes * SelW;

  logic [Width-1:0] patMap [Patterns];
  logic [Width-1:0] activeMap;
  logic [Lanes-1:0] outQ;

  for (genvar p = 0; p < Patterns; p++) begin : gPat
    logic [Width-1:0] patQ;
    logic             hit;
    assign hit       = ctl.wrEn && (ctl.wrPat == PatW'(p));
    assign patMap[p] = patQ;
    if (p == 0) begin : gBoot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < Lanes; i++) patQ[i*SelW +: SelW] <= SelW'(i);
        end else if (hit) begin
          patQ[ctl.wrIdx*SelW +: SelW] <= ctl.wrSel;
        end
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (hit) patQ[ctl.wrIdx*SelW +: SelW] <= ctl.wrSel;
      end
    end
  end

  assign activeMap = patMap[ctl.livePat];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ <= '0;
    end else begin
      for (int o = 0; o < Lanes; o++) outQ[o] <= inLanes[activeMap[o*SelW +: SelW]];
    end
  end
  assign outLanes = outQ;

  assert_inactive_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && ctl.wrPat != ctl.livePat) |=> $stable(activeMap));
  assert_active_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && ctl.wrPat == ctl.livePat)
      |=> (activeMap[$past(ctl.wrIdx)*SelW +: SelW] == $past(ctl.wrSel)));
endmodule

// File: rtl/pattern_xbar.sv
module pattern_xbar
  import xbar_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LaneCount-1:0] inLanes,
  output logic [LaneCount-1:0] outLanes,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [1:0]           cmdOp,
  input  logic [PatW-1:0]      cmdPattern,
  input  logic [SelW-1:0]      cmdOutput,
  input  logic [SelW-1:0]      cmdInput,
  output logic                 loadDone
);
  xbarCtl_t ctl;

  xbar_ctrl #(.Lanes(LaneCount)) u_ctrl (
    .clk, .rstN, .cmdValid, .cmdReady, .cmdOp,
    .cmdPattern, .cmdOutput, .cmdInput, .loadDone, .ctl
  );

  xbar_path #(.Lanes(LaneCount), .Patterns(PatternCount)) u_path (
    .clk, .rstN, .ctl, .inLanes, .outLanes
  );
endmodule

// File: tb/pattern_xbar_tb.sv
module pattern_xbar_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inLanes = '0;
  logic [31:0] outLanes;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = '0;
  logic [4:0]  cmdPattern = '0, cmdOutput = '0, cmdInput = '0;
  logic        loadDone;

  int checks = 0, errors = 0;
  int refMap [4][32];
  int livePat = 0, loadTgt = 0, loadCnt = 0;
  bit loadOpen = 0;
  int unused;

  always #5 clk = ~clk;

  pattern_xbar u_dut (.*);

  function automatic logic [31:0] expOut(logic [31:0] inW);
    logic [31:0] r;
    for (int o = 0; o < 32; o++) r[o] = inW[refMap[livePat][o]];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(int op, int pat, int oIdx, int sel, bit valid = 1'b1);
    @(negedge clk);
    cmdValid = valid; cmdOp = 2'(op);
    cmdPattern = 5'(pat); cmdOutput = 5'(oIdx); cmdInput = 5'(sel);
    @(negedge clk);
    cmdValid = 1'b0;
    if (valid) begin
      case (op)
        0: livePat = pat;
        1: refMap[pat][oIdx] = sel;
        2: begin loadTgt = pat; loadCnt = 0; loadOpen = 1; end
        default: if (loadOpen) begin
          refMap[loadTgt][loadCnt] = sel;
          loadCnt++;
          if (loadCnt == 32) loadOpen = 0;
        end
      endcase
    end
  endtask

  task automatic checkOut(string req, logic [31:0] inW);
    inLanes = inW;
    @(negedge clk);
    check(req, outLanes, expOut(inW));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    unused = $urandom(32'd2024);
    for (int o = 0; o < 32; o++) refMap[0][o] = o;
    // R2: reset state
    inLanes = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R2 out in reset", outLanes, 32'h0);
    check("R2 ready in reset", {31'b0, cmdReady}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 ready after reset", {31'b0, cmdReady}, 32'h1);
    checkOut("R2 identity", 32'hA5C3_0F81);
    checkOut("R1 identity random", $urandom);

    // R7/R8: load map 1 with random selects
    issue(2, 1, 0, 0);
    check("R7 done cleared", {31'b0, loadDone}, 32'h0);
    for (int k = 0; k < 31; k++) issue(3, 0, 0, $urandom_range(31));
    check("R8 not done after 31", {31'b0, loadDone}, 32'h0);
    issue(3, 0, 0, $urandom_range(31));
    check("R8 done after 32", {31'b0, loadDone}, 32'h1);
    issue(3, 0, 0, 3);  // R8: closed load, ignored
    check("R8 done held", {31'b0, loadDone}, 32'h1);
    checkOut("R8 ignored data keeps map 0", $urandom);

    // map 2: every output from input 7 (fan-out), map 3: reversed
    issue(2, 2, 0, 0);
    for (int k = 0; k < 32; k++) issue(3, 0, 0, 7);
    issue(2, 3, 0, 0);
    for (int k = 0; k < 32; k++) issue(3, 0, 0, 31 - k);

    issue(0, 1, 0, 0);
    checkOut("R3 select map 1", $urandom);
    checkOut("R3 select map 1 again", $urandom);
    issue(0, 2, 0, 0);
    checkOut("R1 fan-out high", 32'h0000_0080);
    checkOut("R1 fan-out low", 32'hFFFF_FF7F);
    issue(0, 3, 0, 0);
    checkOut("R7 reversed order", 32'h0000_0001);

    // R5: edit the live map
    issue(1, 3, 5, 9);
    checkOut("R5 live entry write", 32'h0000_0200);
    checkOut("R5 live entry random", $urandom);
    // R6: edit a map that is not live
    issue(1, 1, 0, 30);
    checkOut("R6 inactive write no effect", $urandom);
    issue(0, 1, 0, 0);
    checkOut("R6 R4 edited map restored", $urandom);
    issue(0, 0, 0, 0);
    checkOut("R4 identity restored", $urandom);

    // R9: no valid, no effect
    issue(0, 3, 0, 0, 1'b0);
    checkOut("R9 invalid select ignored", $urandom);
    issue(1, 0, 2, 17, 1'b0);
    checkOut("R9 invalid write ignored", 32'h0000_0004);

    // random mix of select and entry writes on maps 0..3
    for (int n = 0; n < 200; n++) begin
      if ($urandom_range(2) == 0) issue(0, $urandom_range(3), 0, 0);
      else issue(1, $urandom_range(3), $urandom_range(31), $urandom_range(31));
      checkOut("R1 R5 R6 random mix", $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule